// File: doc/BRIEF.md
# Frame-Synchronised Execution Stall Controller

This block sits beside an instruction-executing core and decides, cycle by cycle, whether that core may run an instruction. It combines three reasons for holding the core: a pause state that software sets and clears, a frame-wait state that follows a draw and lasts until the next vertical-blank pulse, and a key-wait state that holds the core until a key is released. The block also holds two 8-bit down-counters, a delay timer and a sound timer, that count at frame rate. It also holds a latch with one bit per key.

The core reports a draw, or a request to wait for a key, in a cycle where `exec_en_o` is high. Strobes that arrive while execution is blocked are ignored. A key-wait request with no key captured tells the core to replay the same instruction (`replay_o`) and then blocks it. Releasing a key in that state captures the key code and lifts the block. The replayed request then gets the key on `key_ret_code_o` and consumes the capture. A single-step input lets a paused core run exactly one instruction. A soft-reset input lifts both waits and tells the core to restart at the reset address.

All pins are plain strobes and levels. No path in the block applies back-pressure, so every event is taken in the cycle it is presented and none is held or queued.

Top module: `frame_stall_ctrl`

## Requirements
- R1: `exec_en_o` is low whenever pause, frame-wait or key-wait is active. The one exception is the single-step cycle of R10, which is still blocked by key-wait. After reset all three states are clear and `exec_en_o` is high.
- R2: A `draw_i` strobe in an executing cycle with `draw_wait_en_i` high sets frame-wait from the next cycle. A `vblank_i` pulse clears it from the cycle after the pulse. A draw with `draw_wait_en_i` low causes no stall. If a draw and a vblank fall in the same cycle, the draw wins.
- R3: On a `vblank_i` pulse while not paused, each timer that is above zero goes down by one in the next cycle. A timer at zero stays at zero. While paused, both timers hold their values.
- R4: `dly_load_i` or `snd_load_i` writes `timer_data_i` into that timer in the next cycle. The load overrides a decrement in the same cycle.
- R5: `sound_on_o` is high exactly when the sound timer is non-zero.
- R6: A press event sets bit `key_code_i` of `key_down_o` only when the code is 0 to 15. Codes 16 to 31 leave the latch unchanged.
- R7: A release event with a valid code clears that key's bit. If key-wait is active, the release also captures the code and ends key-wait from the next cycle.
- R8: A key-wait request in an executing cycle with no capture raises `replay_o` in that same cycle, and key-wait is set from the next cycle. With a capture held, the request instead raises `key_ret_valid_o` with the captured code in that cycle, and the capture is cleared from the next cycle.
- R9: `soft_reset_i` raises `pc_force_o` in the same cycle, with `pc_force_addr_o` = 0x200. It clears frame-wait and key-wait from the next cycle, and this takes priority over a simultaneous set.
- R10: `step_i` while paused gives exactly one cycle with `exec_en_o` high, starting in the next cycle. Frame-wait is clear after that cycle, even if a draw occurred in it, and pause stays set.
- R11: `pause_req_i` sets pause and `run_req_i` clears it, both from the next cycle. If both arrive in the same cycle, pause wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_i | input | 1 | Vertical-blank pulse |
| key_press_i | input | 1 | Key press event |
| key_release_i | input | 1 | Key release event |
| key_code_i | input | 5 | Key code for press or release |
| draw_i | input | 1 | Core issued a draw this cycle |
| draw_wait_en_i | input | 1 | Draw stalls until the next vblank |
| keywait_req_i | input | 1 | Core requests a key this cycle |
| dly_load_i | input | 1 | Load the delay timer |
| snd_load_i | input | 1 | Load the sound timer |
| timer_data_i | input | 8 | Timer load value |
| soft_reset_i | input | 1 | Soft reset request |
| step_i | input | 1 | Single-step request |
| pause_req_i | input | 1 | Enter pause |
| run_req_i | input | 1 | Leave pause |
| exec_en_o | output | 1 | Core may execute this cycle |
| replay_o | output | 1 | Re-execute the current instruction |
| key_ret_valid_o | output | 1 | Captured key returned this cycle |
| key_ret_code_o | output | 5 | Returned key code |
| key_down_o | output | 16 | Key latch state |
| dly_o | output | 8 | Delay timer value |
| snd_o | output | 8 | Sound timer value |
| sound_on_o | output | 1 | Sound timer non-zero |
| pc_force_o | output | 1 | Core must load the reset address |
| pc_force_addr_o | output | 12 | Reset address |

## Verification
The key latch is swept over all 32 codes of a 5-bit field, with a press and a release for each code. This separates the 16 valid keys from the out-of-range codes that must be ignored. Both timers are loaded with every 8-bit value, which exposes errors in the load path and in the sound-active compare. Countdowns then run through zero, under pause, and with a load in the same cycle as a vblank, which checks that the counters hold at zero and that priority between load and decrement is right. Stall sequences cover a draw with the wait bit on and off, a key wait released by a key, soft reset out of a frame wait, and a single step taken while a draw is pending. Together these show which state lifts which stall.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int unsigned KEYS_DEF   = 16;
  localparam int unsigned CODE_W_DEF = 5;
  localparam int unsigned TMR_W_DEF  = 8;
  localparam int unsigned PC_W_DEF   = 12;

  typedef enum int unsigned {
    TMR_DELAY = 0,
    TMR_SOUND = 1,
    TMR_COUNT = 2
  } tmr_sel_e;
endpackage

// File: rtl/fsc_keys.sv
module fsc_keys #(
  parameter int unsigned NUM_KEYS = 16,
  parameter int unsigned CODE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                press_i,
  input  logic                release_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                key_wait_i,
  input  logic                consume_i,
  output logic [NUM_KEYS-1:0] key_down_o,
  output logic                cap_event_o,
  output logic                cap_valid_o,
  output logic [CODE_W-1:0]   cap_code_o
);
  logic                code_ok;
  logic [NUM_KEYS-1:0] down_q;
  logic                cap_valid_q;
  logic [CODE_W-1:0]   cap_code_q;

  assign code_ok     = 32'(code_i) < 32'(NUM_KEYS);
  assign cap_event_o = release_i && code_ok && key_wait_i;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    localparam logic [CODE_W-1:0] KCODE = CODE_W'(k);
    logic hit;
    assign hit = code_ok && (code_i == KCODE);
    always_ff @(posedge clk) begin
      if (!rst_n)                down_q[k] <= 1'b0;
      else if (release_i && hit) down_q[k] <= 1'b0;
      else if (press_i && hit)   down_q[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid_q <= 1'b0;
      cap_code_q  <= '0;
    end else if (cap_event_o) begin
      cap_valid_q <= 1'b1;
      cap_code_q  <= code_i;
    end else if (consume_i) begin
      cap_valid_q <= 1'b0;
    end
  end

  assign key_down_o  = down_q;
  assign cap_valid_o = cap_valid_q;
  assign cap_code_o  = cap_code_q;

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (press_i && !release_i && !code_ok) |=> $stable(down_q)); // R6
  AST_CAPTURE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event_o |=> (cap_valid_q && cap_code_q == $past(code_i))); // R7
endmodule

// File: rtl/fsc_timer.sv
module fsc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      val_q <= '0;
    else if (load_i)                 val_q <= data_i;
    else if (tick_i && val_q != '0)  val_q <= val_q - 1'b1;
  end

  assign val_o = val_q;

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && val_q == '0) |=> (val_q == '0)); // R3
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (val_q == $past(data_i))); // R4
endmodule

// File: rtl/fsc_gate.sv
module fsc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_req_i,
  input  logic run_req_i,
  input  logic step_i,
  input  logic vblank_i,
  input  logic draw_i,
  input  logic draw_wait_en_i,
  input  logic keywait_req_i,
  input  logic soft_reset_i,
  input  logic cap_event_i,
  input  logic cap_valid_i,
  output logic exec_en_o,
  output logic paused_o,
  output logic key_wait_o,
  output logic replay_o,
  output logic consume_o
);
  logic pause_q, step_q, frame_wait_q, key_wait_q;
  logic exec_en, draw_stall, kw_req;

  assign exec_en    = !key_wait_q && (step_q || (!pause_q && !frame_wait_q));
  assign draw_stall = exec_en && draw_i && draw_wait_en_i;
  assign kw_req     = exec_en && keywait_req_i;
  assign replay_o   = kw_req && !cap_valid_i;
  assign consume_o  = kw_req && cap_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_q      <= 1'b0;
      step_q       <= 1'b0;
      frame_wait_q <= 1'b0;
      key_wait_q   <= 1'b0;
    end else begin
      if (pause_req_i)    pause_q <= 1'b1;
      else if (run_req_i) pause_q <= 1'b0;

      step_q <= !step_q && step_i && pause_q && !run_req_i;

      if (soft_reset_i || step_q) frame_wait_q <= 1'b0;
      else if (draw_stall)        frame_wait_q <= 1'b1;
      else if (vblank_i)          frame_wait_q <= 1'b0;

      if (soft_reset_i || cap_event_i) key_wait_q <= 1'b0;
      else if (replay_o)               key_wait_q <= 1'b1;
    end
  end

  assign exec_en_o  = exec_en;
  assign paused_o   = pause_q;
  assign key_wait_o = key_wait_q;

  AST_FRAME_WAIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_wait_q) |-> $past(draw_i && draw_wait_en_i)); // R2
  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_i |=> (!frame_wait_q && !key_wait_q)); // R9
  AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && !run_req_i) |=> (!step_q && pause_q && !frame_wait_q)); // R10
  AST_KEY_WAIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_o && !soft_reset_i) |=> key_wait_q); // R8
  AST_NO_RET_AND_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(replay_o && consume_o)); // R8
endmodule

// File: rtl/frame_stall_ctrl.sv
module frame_stall_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned           NUM_KEYS = KEYS_DEF,
  parameter int unsigned           CODE_W   = CODE_W_DEF,
  parameter int unsigned           TMR_W    = TMR_W_DEF,
  parameter int unsigned           PC_W     = PC_W_DEF,
  parameter logic [PC_W_DEF-1:0]   RESET_PC = 12'h200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vblank_i,
  input  logic                key_press_i,
  input  logic                key_release_i,
  input  logic [CODE_W-1:0]   key_code_i,
  input  logic                draw_i,
  input  logic                draw_wait_en_i,
  input  logic                keywait_req_i,
  input  logic                dly_load_i,
  input  logic                snd_load_i,
  input  logic [TMR_W-1:0]    timer_data_i,
  input  logic                soft_reset_i,
  input  logic                step_i,
  input  logic                pause_req_i,
  input  logic                run_req_i,
  output logic                exec_en_o,
  output logic                replay_o,
  output logic                key_ret_valid_o,
  output logic [CODE_W-1:0]   key_ret_code_o,
  output logic [NUM_KEYS-1:0] key_down_o,
  output logic [TMR_W-1:0]    dly_o,
  output logic [TMR_W-1:0]    snd_o,
  output logic                sound_on_o,
  output logic                pc_force_o,
  output logic [PC_W-1:0]     pc_force_addr_o
);
  localparam int unsigned NT = int'(TMR_COUNT);

  logic              paused, key_wait, cap_event, cap_valid, consume;
  logic              tmr_tick;
  logic [NT-1:0]     tmr_load;
  logic [TMR_W-1:0]  tmr_val [NT];

  fsc_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .pause_req_i    (pause_req_i),
    .run_req_i      (run_req_i),
    .step_i         (step_i),
    .vblank_i       (vblank_i),
    .draw_i         (draw_i),
    .draw_wait_en_i (draw_wait_en_i),
    .keywait_req_i  (keywait_req_i),
    .soft_reset_i   (soft_reset_i),
    .cap_event_i    (cap_event),
    .cap_valid_i    (cap_valid),
    .exec_en_o      (exec_en_o),
    .paused_o       (paused),
    .key_wait_o     (key_wait),
    .replay_o       (replay_o),
    .consume_o      (consume)
  );

  fsc_keys #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_keys (
    .clk         (clk),
    .rst_n       (rst_n),
    .press_i     (key_press_i),
    .release_i   (key_release_i),
    .code_i      (key_code_i),
    .key_wait_i  (key_wait),
    .consume_i   (consume),
    .key_down_o  (key_down_o),
    .cap_event_o (cap_event),
    .cap_valid_o (cap_valid),
    .cap_code_o  (key_ret_code_o)
  );

  assign tmr_tick = vblank_i && !paused;
  assign tmr_load[int'(TMR_DELAY)] = dly_load_i;
  assign tmr_load[int'(TMR_SOUND)] = snd_load_i;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    fsc_timer #(.W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tmr_tick),
      .load_i (tmr_load[t]),
      .data_i (timer_data_i),
      .val_o  (tmr_val[t])
    );
  end

  assign dly_o           = tmr_val[int'(TMR_DELAY)];
  assign snd_o           = tmr_val[int'(TMR_SOUND)];
  assign sound_on_o      = snd_o != '0;
  assign key_ret_valid_o = consume;
  assign pc_force_o      = soft_reset_i;
  assign pc_force_addr_o = PC_W'(RESET_PC);

  AST_PAUSED_TIMERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !dly_load_i && !snd_load_i) |=> ($stable(dly_o) && $stable(snd_o))); // R3
  AST_BLOCKED_WHEN_KEY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    key_wait |-> !exec_en_o); // R1
endmodule

// File: tb/frame_stall_ctrl_bench.sv
module frame_stall_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vblank_i, key_press_i, key_release_i;
  logic [4:0]  key_code_i;
  logic        draw_i, draw_wait_en_i, keywait_req_i;
  logic        dly_load_i, snd_load_i;
  logic [7:0]  timer_data_i;
  logic        soft_reset_i, step_i, pause_req_i, run_req_i;
  logic        exec_en_o, replay_o, key_ret_valid_o;
  logic [4:0]  key_ret_code_o;
  logic [15:0] key_down_o;
  logic [7:0]  dly_o, snd_o;
  logic        sound_on_o, pc_force_o;
  logic [11:0] pc_force_addr_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frame_stall_ctrl u_frame_stall_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    vblank_i = 0; key_press_i = 0; key_release_i = 0; key_code_i = 0;
    draw_i = 0; keywait_req_i = 0; dly_load_i = 0; snd_load_i = 0;
    timer_data_i = 0; soft_reset_i = 0; step_i = 0; pause_req_i = 0; run_req_i = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; draw_wait_en_i = 0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 reset exec_en", exec_en_o, 1);
    chk("R6 reset keys", key_down_o, 0);
    chk("R3 reset dly", dly_o, 0);
    chk("R5 reset sound_on", sound_on_o, 0);
    chk("R8 reset ret", key_ret_valid_o, 0);

    // R6/R7 sweep every code
    for (int c = 0; c < 32; c++) begin
      key_press_i = 1; key_code_i = 5'(c); tick(); idle();
      chk("R6 press", key_down_o, (c < 16) ? (32'd1 << c) : 32'd0);
      key_release_i = 1; key_code_i = 5'(c); tick(); idle();
      chk("R7 release", key_down_o, 0);
    end

    // R4/R5 sweep every load value
    for (int v = 0; v < 256; v++) begin
      dly_load_i = 1; snd_load_i = 1; timer_data_i = 8'(v); tick(); idle();
      chk("R4 dly load", dly_o, v);
      chk("R4 snd load", snd_o, v);
      chk("R5 sound_on", sound_on_o, (v != 0) ? 1 : 0);
    end

    // R3 countdown through zero
    dly_load_i = 1; timer_data_i = 3; tick(); idle();
    snd_load_i = 1; timer_data_i = 1; tick(); idle();
    for (int i = 0; i < 5; i++) begin
      vblank_i = 1; tick(); idle();
      chk("R3 dly count", dly_o, (i < 3) ? (2 - i) : 0);
      chk("R3 snd count", snd_o, 0);
      chk("R5 sound off", sound_on_o, 0);
    end
    // R4 load beats decrement
    vblank_i = 1; dly_load_i = 1; timer_data_i = 9; tick(); idle();
    chk("R4 load over vblank", dly_o, 9);
    // R3 paused hold
    pause_req_i = 1; tick(); idle();
    vblank_i = 1; tick(); idle();
    chk("R3 paused hold", dly_o, 9);
    run_req_i = 1; tick(); idle();
    vblank_i = 1; tick(); idle();
    chk("R3 resume count", dly_o, 8);

    // R2 draw stalls
    draw_wait_en_i = 0; draw_i = 1; tick(); idle();
    chk("R2 no stall when off", exec_en_o, 1);
    draw_wait_en_i = 1; draw_i = 1; tick(); idle();
    chk("R2 stall", exec_en_o, 0);
    repeat (3) tick();
    chk("R1 stall holds", exec_en_o, 0);
    vblank_i = 1; draw_i = 0; tick(); idle();
    chk("R2 vblank clears", exec_en_o, 1);
    draw_i = 1; vblank_i = 1; tick(); idle();
    chk("R2 draw wins over vblank", exec_en_o, 0);
    vblank_i = 1; tick(); idle();

    // R8/R7 key wait
    keywait_req_i = 1; #1;
    chk("R8 replay", replay_o, 1);
    chk("R8 no ret", key_ret_valid_o, 0);
    tick(); idle();
    chk("R8 key wait blocks", exec_en_o, 0);
    key_press_i = 1; key_code_i = 7; tick(); idle();
    chk("R7 press no wake", exec_en_o, 0);
    key_release_i = 1; key_code_i = 20; tick(); idle();
    chk("R7 bad code no wake", exec_en_o, 0);
    key_release_i = 1; key_code_i = 7; tick(); idle();
    chk("R7 release wakes", exec_en_o, 1);
    keywait_req_i = 1; #1;
    chk("R8 ret valid", key_ret_valid_o, 1);
    chk("R8 ret code", key_ret_code_o, 7);
    chk("R8 no replay", replay_o, 0);
    tick(); idle();
    chk("R8 still running", exec_en_o, 1);
    keywait_req_i = 1; #1;
    chk("R8 capture consumed", replay_o, 1);
    tick(); idle();

    // R9 soft reset lifts key wait
    soft_reset_i = 1; #1;
    chk("R9 pc force", pc_force_o, 1);
    chk("R9 pc addr", pc_force_addr_o, 12'h200);
    tick(); idle();
    chk("R9 key wait cleared", exec_en_o, 1);
    draw_i = 1; tick(); idle();
    chk("R2 stall again", exec_en_o, 0);
    soft_reset_i = 1; tick(); idle();
    chk("R9 frame wait cleared", exec_en_o, 1);
    chk("R9 pc force drops", pc_force_o, 0);

    // R10/R11 pause and single step
    pause_req_i = 1; tick(); idle();
    chk("R11 paused", exec_en_o, 0);
    step_i = 1; tick(); idle();
    chk("R10 step cycle", exec_en_o, 1);
    draw_i = 1; tick(); idle();
    chk("R10 paused after step", exec_en_o, 0);
    tick();
    chk("R10 stays paused", exec_en_o, 0);
    pause_req_i = 1; run_req_i = 1; tick(); idle();
    chk("R11 pause wins", exec_en_o, 0);
    run_req_i = 1; tick(); idle();
    chk("R10 frame wait cleared by step", exec_en_o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule